// File: doc/BRIEF.md
# Link Autonegotiation Arbitration Resolver

This block decides the operating speed and duplex of a twisted-pair link. A fast-link-pulse receiver decodes the partner's 16-bit code words and passes them in. Two other detectors report legacy normal link pulses and 100 Mb/s idle. The block accepts the partner's word only after it has arrived three times in a row. It then waits for a second run of three that agrees with the first. When that run arrives, it intersects the partner's abilities with the locally advertised set and picks the best common mode.

When only link pulses or idle are seen, the block falls back to parallel detection. This sets the speed from the detected signal and always chooses half duplex. Negotiation starts over after reset, a restart request, or link loss. It is switched off while fibre mode is selected. The result is held until the next restart. Timing decode of the pulses and transmission of the local word are handled elsewhere.

Top module: `autoneg_resolver`

## Requirements
- R1: After reset, and one cycle after a restart_i or link_lost_i pulse, done_o, spd100_o and full_dup_o are 0, partner_word_o is 0, and the identical-word count is cleared.
- R2: Three consecutive valid code words that agree in every bit except bit 14 (the acknowledge bit) are captured. The third word, as received, appears on partner_word_o one cycle after it is presented.
- R3: A word that differs from the previous one in any bit other than bit 14 restarts the run count at one, and that word counts as the first of a new run.
- R4: After a capture, a second run of three words that agrees with the stored word (ignoring bit 14) starts resolution. done_o rises one cycle after the sixth word, and not before.
- R5: If the second run disagrees with the stored word outside bit 14, the stored word is replaced by the new run's word. done_o stays low, and the block waits for another confirming run.
- R6: Partner abilities are code-word bits 8:5 (bit 5 = 10 half, bit 6 = 10 full, bit 7 = 100 half, bit 8 = 100 full). Local abilities are local_abil_i bits 3:0 in the same order. The resolved mode is the highest common one in the order 100 full, 100 half, 10 full, 10 half. spd100_o=1 means 100 Mb/s, and full_dup_o=1 means full duplex.
- R7: If the confirmed partner word shares no ability with local_abil_i, done_o stays low and the block goes back to waiting for a first run.
- R8: While a result is pending, a cycle with nlp_seen_i or idle_seen_i high resolves on the next cycle to half duplex, with done_o=1. spd100_o=1 if idle_seen_i was high (idle wins when both are high), and 0 otherwise. partner_word_o is left unchanged.
- R9: Once done_o is high, code words and detection flags have no effect. Outputs stay constant until restart, link loss or fibre mode.
- R10: While fiber_mode_i is high, all outputs are forced to 0 one cycle later and all inputs are ignored. After it falls, the block waits for a fresh first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | Restart request pulse |
| link_lost_i | input | 1 | Link loss pulse, restarts negotiation |
| fiber_mode_i | input | 1 | Fibre mode selected, negotiation disabled |
| cw_valid_i | input | 1 | A decoded code word is presented this cycle |
| cw_data_i | input | 16 | Decoded partner code word |
| local_abil_i | input | 4 | Local advertised abilities (10H, 10F, 100H, 100F) |
| nlp_seen_i | input | 1 | Normal link pulses detected |
| idle_seen_i | input | 1 | 100 Mb/s idle detected |
| spd100_o | output | 1 | Resolved speed, 1 = 100 Mb/s |
| full_dup_o | output | 1 | Resolved duplex, 1 = full |
| done_o | output | 1 | Resolution complete |
| partner_word_o | output | 16 | Stored partner code word |

## Verification
The hardest case to reach is a second run that disagrees with the first. It needs two complete, distinct runs of three, with the acknowledge bit flipped inside each run so that the masking is exercised at the same time. The bench gets there with a per-scenario task. The task first checks that the replacement word is visible and done_o is still low. It then sends a confirming run, whose reduced ability set must resolve to a lower-priority mode. A similar path leads into the no-common-ability case: the block must drop back to waiting, and the bench proves this with a further full exchange.

// File: rtl/anr_pkg.sv
// Package: shared types for the autonegotiation resolver.
// Assumes a four-entry ability set ranked 10H < 10F < 100H < 100F.
package anr_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_LISTEN  = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_DONE    = 2'd3
    } anr_state_e;

    typedef struct packed {
        logic spd100;
        logic full;
    } anr_mode_t;

    // Map a rank (0..3) to speed/duplex: bit 1 selects 100 Mb/s, bit 0 full duplex.
    function automatic anr_mode_t mode_from_rank(input logic [1:0] rank);
        anr_mode_t m;
        m.spd100 = rank[1];
        m.full   = rank[0];
        return m;
    endfunction

endpackage

// File: rtl/anr_word_matcher.sv
// Module: anr_word_matcher
// Counts consecutive code words that agree outside the acknowledge bit.
// It raises hit_o, in the same cycle, on the word that completes a run of MATCH_CNT.
// After a hit the count starts from zero. A mismatch restarts the count at one.
// Assumes MATCH_CNT >= 2 and that clr_i dominates everything else.
module anr_word_matcher #(
    parameter int CW_W      = 16,
    parameter int ACK_POS   = 14,
    parameter int MATCH_CNT = 3,
    localparam int CNT_W    = $clog2(MATCH_CNT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic            valid_i,
    input  logic [CW_W-1:0] word_i,
    output logic            hit_o,
    output logic [CW_W-1:0] hit_word_o
);
    localparam logic [CW_W-1:0] CMP_MASK = ~(CW_W'(1) << ACK_POS);

    logic [CW_W-1:0]  last_q;
    logic [CNT_W-1:0] cnt_q;
    logic             same;
    logic             take;

    // Compare the incoming word with the previous one, acknowledge bit excluded.
    always_comb begin
        same       = ((word_i ^ last_q) & CMP_MASK) == '0;
        take       = valid_i && en_i && !clr_i;
        hit_o      = take && (cnt_q == CNT_W'(MATCH_CNT - 1)) && same;
        hit_word_o = word_i;
    end

    // Track the current run length and the word it is built on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (clr_i) begin
            cnt_q  <= '0;
        end else if (take) begin
            if (hit_o) begin
                cnt_q  <= '0;
            end else if (cnt_q == '0 || !same) begin
                cnt_q  <= CNT_W'(1);
                last_q <= word_i;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/anr_prio_pick.sv
// Module: anr_prio_pick
// Intersects local and partner ability sets and returns the highest set index.
// Assumes the ability vector is ordered lowest priority at bit 0.
module anr_prio_pick #(
    parameter int NUM_ABIL = 4,
    localparam int SEL_W   = $clog2(NUM_ABIL)
) (
    input  logic [NUM_ABIL-1:0] local_i,
    input  logic [NUM_ABIL-1:0] partner_i,
    output logic                any_o,
    output logic [SEL_W-1:0]    sel_o
);
    logic [NUM_ABIL-1:0] common;

    // Scan upward so the highest common ability is the last one kept.
    always_comb begin
        common = local_i & partner_i;
        any_o  = 1'b0;
        sel_o  = '0;
        for (int i = 0; i < NUM_ABIL; i++) begin
            if (common[i]) begin
                any_o = 1'b1;
                sel_o = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/anr_ctrl.sv
// Module: anr_ctrl
// Negotiation sequencer: first run capture, confirmation, resolution,
// parallel-detect fallback, restart and fibre disable.
// Assumes the matcher hit is same-cycle and that all outputs are registered here.
module anr_ctrl
    import anr_pkg::*;
#(
    parameter int CW_W    = 16,
    parameter int ACK_POS = 14,
    parameter int SEL_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            link_lost_i,
    input  logic            fiber_mode_i,
    input  logic            nlp_seen_i,
    input  logic            idle_seen_i,
    input  logic            hit_i,
    input  logic [CW_W-1:0] hit_word_i,
    input  logic            any_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic            mclr_o,
    output logic            men_o,
    output logic [CW_W-1:0] pw_o,
    output logic            spd100_o,
    output logic            full_dup_o,
    output logic            done_o
);
    localparam logic [CW_W-1:0] CMP_MASK = ~(CW_W'(1) << ACK_POS);

    anr_state_e      state_q;
    logic [CW_W-1:0] pw_q;
    logic            confirm_eq;
    anr_mode_t       picked;

    // Matcher control and confirmation compare.
    always_comb begin
        mclr_o     = fiber_mode_i || restart_i || link_lost_i ||
                     state_q == ST_OFF || state_q == ST_DONE;
        men_o      = state_q == ST_LISTEN || state_q == ST_CONFIRM;
        confirm_eq = ((hit_word_i ^ pw_q) & CMP_MASK) == '0;
        picked     = mode_from_rank(2'(sel_i));
        pw_o       = pw_q;
    end

    // Sequence negotiation and hold the resolved result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_LISTEN;
            pw_q       <= '0;
            spd100_o   <= 1'b0;
            full_dup_o <= 1'b0;
            done_o     <= 1'b0;
        end else if (fiber_mode_i) begin
            state_q    <= ST_OFF;
            pw_q       <= '0;
            spd100_o   <= 1'b0;
            full_dup_o <= 1'b0;
            done_o     <= 1'b0;
        end else if (restart_i || link_lost_i) begin
            state_q    <= ST_LISTEN;
            pw_q       <= '0;
            spd100_o   <= 1'b0;
            full_dup_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            case (state_q)
                ST_OFF: state_q <= ST_LISTEN;
                ST_LISTEN, ST_CONFIRM: begin
                    if (nlp_seen_i || idle_seen_i) begin
                        state_q    <= ST_DONE;
                        spd100_o   <= idle_seen_i;
                        full_dup_o <= 1'b0;
                        done_o     <= 1'b1;
                    end else if (hit_i) begin
                        if (state_q == ST_LISTEN) begin
                            pw_q    <= hit_word_i;
                            state_q <= ST_CONFIRM;
                        end else if (!confirm_eq) begin
                            pw_q    <= hit_word_i;
                        end else if (any_i) begin
                            state_q    <= ST_DONE;
                            spd100_o   <= picked.spd100;
                            full_dup_o <= picked.full;
                            done_o     <= 1'b1;
                        end else begin
                            state_q <= ST_LISTEN;
                        end
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/autoneg_resolver.sv
// Module: autoneg_resolver (top)
// Resolves link speed and duplex from partner code words or parallel detection.
// Assumes decoded words arrive as single-cycle valid strobes.
module autoneg_resolver #(
    parameter int CW_W      = 16,
    parameter int ACK_POS   = 14,
    parameter int ABIL_LSB  = 5,
    parameter int NUM_ABIL  = 4,
    parameter int MATCH_CNT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart_i,
    input  logic                link_lost_i,
    input  logic                fiber_mode_i,
    input  logic                cw_valid_i,
    input  logic [CW_W-1:0]     cw_data_i,
    input  logic [NUM_ABIL-1:0] local_abil_i,
    input  logic                nlp_seen_i,
    input  logic                idle_seen_i,
    output logic                spd100_o,
    output logic                full_dup_o,
    output logic                done_o,
    output logic [CW_W-1:0]     partner_word_o
);
    localparam int SEL_W = $clog2(NUM_ABIL);

    logic            mclr, men, hit, any;
    logic [CW_W-1:0] hit_word;
    logic [SEL_W-1:0] sel;

    anr_word_matcher #(.CW_W(CW_W), .ACK_POS(ACK_POS), .MATCH_CNT(MATCH_CNT)) u_match (
        .clk(clk), .rst_n(rst_n), .clr_i(mclr), .en_i(men),
        .valid_i(cw_valid_i), .word_i(cw_data_i),
        .hit_o(hit), .hit_word_o(hit_word)
    );

    anr_prio_pick #(.NUM_ABIL(NUM_ABIL)) u_pick (
        .local_i(local_abil_i),
        .partner_i(partner_word_o[ABIL_LSB +: NUM_ABIL]),
        .any_o(any), .sel_o(sel)
    );

    anr_ctrl #(.CW_W(CW_W), .ACK_POS(ACK_POS), .SEL_W(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .link_lost_i(link_lost_i),
        .fiber_mode_i(fiber_mode_i), .nlp_seen_i(nlp_seen_i), .idle_seen_i(idle_seen_i),
        .hit_i(hit), .hit_word_i(hit_word), .any_i(any), .sel_i(sel),
        .mclr_o(mclr), .men_o(men), .pw_o(partner_word_o),
        .spd100_o(spd100_o), .full_dup_o(full_dup_o), .done_o(done_o)
    );

endmodule

// File: rtl/anr_checker.sv
// Module: anr_checker
// Concurrent properties on the resolver's ports, bound into the top.
module anr_checker #(
    parameter int CW_W     = 16,
    parameter int ABIL_LSB = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            restart_i,
    input logic            link_lost_i,
    input logic            fiber_mode_i,
    input logic            spd100_o,
    input logic            full_dup_o,
    input logic            done_o,
    input logic [CW_W-1:0] partner_word_o
);
    // R1
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i || link_lost_i) |=> (!done_o && partner_word_o == '0));

    // R10
    fiber_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode_i |=> (!done_o && !spd100_o && !full_dup_o));

    // R9
    result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !restart_i && !link_lost_i && !fiber_mode_i) |=>
        (done_o && $stable(spd100_o) && $stable(full_dup_o) && $stable(partner_word_o)));

    // R6
    full_needs_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && full_dup_o) |->
        (partner_word_o[ABIL_LSB+1] || partner_word_o[ABIL_LSB+3]));
endmodule

bind autoneg_resolver anr_checker #(.CW_W(CW_W), .ABIL_LSB(ABIL_LSB)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .link_lost_i(link_lost_i),
    .fiber_mode_i(fiber_mode_i), .spd100_o(spd100_o), .full_dup_o(full_dup_o),
    .done_o(done_o), .partner_word_o(partner_word_o)
);

// File: tb/autoneg_resolver_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module autoneg_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart_i = 1'b0, link_lost_i = 1'b0, fiber_mode_i = 1'b0;
    logic        cw_valid_i = 1'b0;
    logic [15:0] cw_data_i = '0;
    logic [3:0]  local_abil_i = 4'hF;
    logic        nlp_seen_i = 1'b0, idle_seen_i = 1'b0;
    logic        spd100_o, full_dup_o, done_o;
    logic [15:0] partner_word_o;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // Code words: ability bits 8:5, selector field 0x01, ack is bit 14.
    localparam logic [15:0] W_ALL  = 16'h01E1;
    localparam logic [15:0] W_10   = 16'h0061;
    localparam logic [15:0] W_100F = 16'h0101;
    localparam logic [15:0] W_10H  = 16'h0021;
    localparam logic [15:0] ACK    = 16'h4000;

    always #2.5 clk = ~clk;

    autoneg_resolver uut (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .link_lost_i(link_lost_i),
        .fiber_mode_i(fiber_mode_i), .cw_valid_i(cw_valid_i), .cw_data_i(cw_data_i),
        .local_abil_i(local_abil_i), .nlp_seen_i(nlp_seen_i), .idle_seen_i(idle_seen_i),
        .spd100_o(spd100_o), .full_dup_o(full_dup_o), .done_o(done_o),
        .partner_word_o(partner_word_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic d, input logic s, input logic f);
        chk({req, " done"}, 32'(done_o), 32'(d));
        chk({req, " speed"}, 32'(spd100_o), 32'(s));
        chk({req, " duplex"}, 32'(full_dup_o), 32'(f));
    endtask

    task automatic send_word(input logic [15:0] w);
        cw_valid_i = 1'b1; cw_data_i = w;
        @(negedge clk);
        cw_valid_i = 1'b0;
    endtask

    task automatic send_run(input logic [15:0] w);
        send_word(w); send_word(w | ACK); send_word(w);
    endtask

    task automatic do_restart();
        restart_i = 1'b1; @(negedge clk); restart_i = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        chk_out("R1 reset", 0, 0, 0);
        chk("R1 reset word", 32'(partner_word_o), 0);
    endtask

    // R2, R4: full exchange with ack toggling, done timing
    task automatic t_basic();
        do_restart();
        send_word(W_ALL); send_word(W_ALL | ACK);
        chk("R2 no capture after two", 32'(partner_word_o), 0);
        send_word(W_ALL);
        chk("R2 capture third word", 32'(partner_word_o), 32'(W_ALL));
        send_word(W_ALL | ACK); send_word(W_ALL);
        chk("R4 done low before sixth", 32'(done_o), 0);
        send_word(W_ALL | ACK);
        chk_out("R4 done after sixth", 1, 1, 1);
    endtask

    // R3: mismatch restarts run at one
    task automatic t_mismatch();
        do_restart();
        send_word(W_ALL); send_word(W_ALL); send_word(W_10); send_word(W_ALL); send_word(W_ALL);
        chk("R3 broken run not captured", 32'(partner_word_o), 0);
        do_restart();
        send_word(W_ALL); send_word(W_ALL); send_word(W_10); send_word(W_10); send_word(W_10);
        chk("R3 new run counted from mismatch", 32'(partner_word_o), 32'(W_10));
    endtask

    // R5: second run differs
    task automatic t_replace();
        local_abil_i = 4'hF;
        do_restart();
        send_run(W_ALL); send_run(W_10);
        chk("R5 stored word replaced", 32'(partner_word_o), 32'(W_10));
        chk("R5 no done on disagreement", 32'(done_o), 0);
        send_run(W_10);
        chk_out("R5 resolve after confirm", 1, 0, 1);
    endtask

    // R6: priority across local sets
    task automatic t_prio(input logic [3:0] loc, input logic s, input logic f);
        local_abil_i = loc;
        do_restart();
        send_run(W_ALL); send_run(W_ALL);
        chk_out("R6 priority", 1, s, f);
    endtask

    // R7: no common ability
    task automatic t_nocommon();
        local_abil_i = 4'b0001;
        do_restart();
        send_run(W_100F); send_run(W_100F);
        chk("R7 no done without common", 32'(done_o), 0);
        send_run(W_10H); send_run(W_10H);
        chk_out("R7 back to waiting then resolve", 1, 0, 0);
        local_abil_i = 4'hF;
    endtask

    // R8: parallel detection
    task automatic t_parallel(input logic nlp, input logic idle, input logic s);
        do_restart();
        nlp_seen_i = nlp; idle_seen_i = idle;
        @(negedge clk);
        nlp_seen_i = 1'b0; idle_seen_i = 1'b0;
        chk_out("R8 parallel detect", 1, s, 0);
        chk("R8 word untouched", 32'(partner_word_o), 0);
    endtask

    // R9: result held, inputs ignored
    task automatic t_hold();
        local_abil_i = 4'hF;
        do_restart();
        send_run(W_ALL); send_run(W_ALL);
        send_run(W_10H); send_run(W_10H);
        nlp_seen_i = 1'b1; @(negedge clk); nlp_seen_i = 1'b0;
        chk_out("R9 result held", 1, 1, 1);
        chk("R9 word held", 32'(partner_word_o), 32'(W_ALL));
        link_lost_i = 1'b1; @(negedge clk); link_lost_i = 1'b0;
        chk_out("R1 link loss clears", 0, 0, 0);
        chk("R1 link loss word", 32'(partner_word_o), 0);
    endtask

    // R10: fibre mode disables negotiation
    task automatic t_fiber();
        do_restart();
        send_run(W_ALL); send_run(W_ALL);
        fiber_mode_i = 1'b1; @(negedge clk);
        chk_out("R10 fibre forces off", 0, 0, 0);
        send_run(W_ALL); send_run(W_ALL);
        idle_seen_i = 1'b1; @(negedge clk); idle_seen_i = 1'b0;
        chk_out("R10 inputs ignored", 0, 0, 0);
        chk("R10 word cleared", 32'(partner_word_o), 0);
        fiber_mode_i = 1'b0; @(negedge clk);
        send_word(W_10H); send_word(W_10H);
        chk("R10 fresh run after release", 32'(partner_word_o), 0);
        send_word(W_10H); send_run(W_10H);
        chk_out("R10 resolve after release", 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_replace();
        t_prio(4'b1111, 1, 1);
        t_prio(4'b0111, 1, 0);
        t_prio(4'b0011, 0, 1);
        t_prio(4'b0001, 0, 0);
        local_abil_i = 4'hF;
        t_nocommon();
        t_parallel(1, 0, 0);
        t_parallel(0, 1, 1);
        t_parallel(1, 1, 1);
        t_hold();
        t_fiber();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule